// File: doc/BRIEF.md
# Priority Memory-Map Decoder

This block turns a 24-bit host bus address into a single target choice for a cartridge that holds a boot ROM, a 512K PSRAM, a battery-backed SRAM, a bank of control ports and a removable 1M data pack. A committed set of mapping bits (bits 2 to 12 of the control register file) decides where the boot ROM, PSRAM and an external-memory window appear. Address lines are rearranged in either a LoROM model (32K per bank, upper half) or a HiROM model (full 64K banks). When several regions claim one address, a fixed priority settles the outcome: boot ROM first, then PSRAM, then the external-memory window, then the data pack.

The logic is purely combinational. Alongside the one-hot select it computes a translated offset for each device, and a write-enable for the data pack. The external-memory window has no device behind it. When it is enabled it punches a hole, reported as its own select, that the bus fabric serves as open bus.

Top module: `prio_map_decoder`

## Requirements
- R1: Slow banks 00-0F at offsets 5000-5FFF select the control ports (sel bit 5), with ctrl_idx equal to the low nibble of the bank.
- R2: Slow banks 10-17 at offsets 5000-5FFF select battery SRAM (sel bit 4), with sram_off = {bank[2:0], addr[11:0]}.
- R3: With map_cfg[7] set (slow banks 00-3F) or map_cfg[8] set (fast banks 80-BF), offsets 8000-FFFF select the boot ROM (sel bit 0) above every other region. rom_off = {bank[5:0], addr[14:0]} truncated to ROM_AW bits.
- R4: In LoROM mode (map_cfg[2]=0), map_cfg[6:5] places a 16-bank PSRAM window (sel bit 1) at 00, 20, 40 or 60, plus the same window in the fast half. Banks below 40 use only offsets 8000-FFFF, and banks from 40 up mirror both halves. psram_off = {bank[3:0], addr[14:0]}.
- R5: In LoROM mode, banks 70-7D and F0-FF at offsets 0000-7FFF map to PSRAM whatever map_cfg[6:5] holds, mirrored every 8 banks, with psram_off = {0, bank[2:0], addr[14:0]}.
- R6: In HiROM mode (map_cfg[2]=1), map_cfg[6:5] places an 8-bank PSRAM group at 40/50/60/70 (full banks) and at 00/10/20/30 (offsets 8000-FFFF only), with psram_off = {bank[2:0], addr[15:0]}.
- R7: In HiROM mode, banks 20-3F and A0-BF at offsets 6000-7FFF map 8K PSRAM pieces from offset n*10000h+6000h, with psram_off = {bank[2:0], addr[15:0]}. These pieces ignore map_cfg[6:5]. In LoROM mode the same addresses are open bus.
- R8: map_cfg[3] enables the PSRAM regions in banks 00-7D and map_cfg[4] enables them in banks 80-FF. Each bit acts independently.
- R9: map_cfg[9] (slow) and map_cfg[10] (fast) enable the external-memory hole (sel bit 2), placed by map_cfg[11]. In LoROM it covers 00-1F:8000+ or 40-5F. In HiROM it covers 00-0F:8000+ with 40-4F, or 20-2F:8000+ with 60-6F. The hole ranks below PSRAM and above the data pack.
- R10: Every other address in banks 00-3F/80-BF at 8000-FFFF, and in banks 40-7D/C0-FF, selects the data pack (sel bit 3). pack_off is {bank[5:0], addr[14:0]} in LoROM and {bank[5:0], addr[15:0]} in HiROM, truncated to PACK_AW bits. pack_we is 1 only for a data-pack write (wr=1) with map_cfg[12] set.
- R11: Exactly one sel bit is high for every input. Any address outside the regions above, banks 7E-7F included, selects open bus (sel bit 6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 24 | Host address: bank in [23:16], offset in [15:0] |
| wr | input | 1 | 1 for a write access, 0 for a read |
| map_cfg | input | 11 ([12:2]) | Committed mapping bits 2 to 12 |
| sel | output | 7 | One-hot target: 0 ROM, 1 PSRAM, 2 ext hole, 3 pack, 4 SRAM, 5 ctrl, 6 open |
| pack_we | output | 1 | Data-pack write permitted |
| rom_off | output | ROM_AW | Boot ROM offset |
| psram_off | output | PSRAM_AW | PSRAM offset |
| pack_off | output | PACK_AW | Data-pack offset |
| sram_off | output | 15 | SRAM offset |
| ctrl_idx | output | 4 | Control port index |

## Verification
Every result of this decoder, whether the select, an offset or the write permission, is due in the same cycle its address and mapping bits change, with no register on the way. The driver applies each vector 1 ns after a rising edge and pushes the expected item. The monitor pops and compares at the following falling edge, so the outputs have settled and no sample races the edge that launched the vector. Only the offset of the selected device is compared, because the other offsets are don't-care.

// File: rtl/prio_map_decoder.sv
`timescale 1ns/1ps
module prio_map_decoder #(
  parameter int ROM_AW   = 20,
  parameter int PSRAM_AW = 19,
  parameter int PACK_AW  = 20
) (
  input  logic [23:0]         addr,
  input  logic                wr,
  input  logic [12:2]         map_cfg,
  output logic [6:0]          sel,
  output logic                pack_we,
  output logic [ROM_AW-1:0]   rom_off,
  output logic [PSRAM_AW-1:0] psram_off,
  output logic [PACK_AW-1:0]  pack_off,
  output logic [14:0]         sram_off,
  output logic [3:0]          ctrl_idx
);
  logic        fast, up, hirom, ps_en, rom_en, ext_en, in_space;
  logic [6:0]  b;
  logic [15:0] off;
  logic        lo_win, lo_fix, hi_win, hi_snip;
  logic        rom_hit, ps_hit, ext_hit, pack_hit, sram_hit, ctrl_hit;

  assign fast  = addr[23];
  assign b     = addr[22:16];
  assign off   = addr[15:0];
  assign up    = off[15];
  assign hirom = map_cfg[2];

  assign ps_en  = fast ? map_cfg[4]  : map_cfg[3];
  assign rom_en = fast ? map_cfg[8]  : map_cfg[7];
  assign ext_en = fast ? map_cfg[10] : map_cfg[9];

  assign in_space = fast | (b <= 7'h7D);

  assign rom_hit  = rom_en & ~b[6] & up;

  assign lo_win  = (b[6:5] == map_cfg[6:5]) & ~b[4] & (b[6] | up);
  assign lo_fix  = (b[6:4] == 3'b111) & ~up & in_space;
  assign hi_win  = (b[5:4] == map_cfg[6:5]) & ~b[3] & (b[6] | up);
  assign hi_snip = (b[6:5] == 2'b01) & (off[15:13] == 3'b011);
  assign ps_hit  = ps_en & (hirom ? (hi_win | hi_snip) : (lo_win | lo_fix));

  assign ext_hit = ext_en & (b[6] | up) &
                   (hirom ? (b[5:4] == {map_cfg[11], 1'b0})
                          : (b[6:5] == {map_cfg[11], 1'b0}));

  assign pack_hit = in_space & (b[6] | up);
  assign sram_hit = ~fast & (b[6:3] == 4'b0010) & (off[15:12] == 4'h5);
  assign ctrl_hit = ~fast & (b[6:4] == 3'b000)  & (off[15:12] == 4'h5);

  always_comb begin
    sel = '0;
    if (rom_hit)       sel[0] = 1'b1;
    else if (ps_hit)   sel[1] = 1'b1;
    else if (ext_hit)  sel[2] = 1'b1;
    else if (pack_hit) sel[3] = 1'b1;
    else if (sram_hit) sel[4] = 1'b1;
    else if (ctrl_hit) sel[5] = 1'b1;
    else               sel[6] = 1'b1;
  end

  assign rom_off   = ROM_AW'({b[5:0], off[14:0]});
  assign psram_off = PSRAM_AW'(hirom  ? {b[2:0], off} :
                               lo_fix ? {1'b0, b[2:0], off[14:0]} :
                                        {b[3:0], off[14:0]});
  assign pack_off  = PACK_AW'(hirom ? {b[5:0], off} : {1'b0, b[5:0], off[14:0]});
  assign sram_off  = {b[2:0], off[11:0]};
  assign ctrl_idx  = b[3:0];
  assign pack_we   = sel[3] & wr & map_cfg[12];

  always_comb begin
    if (!$isunknown({addr, wr, map_cfg})) begin
      p_onehot_r11: assert ($onehot(sel))
        else $error("select not one-hot");
      p_we_r10: assert (!pack_we || (sel[3] && wr && map_cfg[12]))
        else $error("pack write without permission");
      p_rom_area_r3: assert (!sel[0] || (addr[15] && !addr[22]))
        else $error("boot ROM outside its area");
      p_sram_area_r2: assert (!sel[4] || (addr[15:12] == 4'h5 && addr[23:19] == 5'b00010))
        else $error("SRAM outside its area");
      p_ext_en_r9: assert (!sel[2] || (addr[23] ? map_cfg[10] : map_cfg[9]))
        else $error("hole without enable");
    end
  end
endmodule

// File: tb/prio_map_decoder_tb.sv
`timescale 1ns/1ps
module prio_map_decoder_tb;
  localparam logic [6:0] S_ROM = 7'b0000001, S_PS = 7'b0000010, S_EXT = 7'b0000100,
                         S_PK  = 7'b0001000, S_SR = 7'b0010000, S_CT  = 7'b0100000,
                         S_OP  = 7'b1000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [23:0] addr = '0;
  logic        wr = 1'b0;
  logic [12:2] map_cfg = '0;
  logic [6:0]  sel;
  logic        pack_we;
  logic [19:0] rom_off;
  logic [18:0] psram_off;
  logic [19:0] pack_off;
  logic [14:0] sram_off;
  logic [3:0]  ctrl_idx;

  prio_map_decoder u_dut (
    .addr(addr), .wr(wr), .map_cfg(map_cfg), .sel(sel), .pack_we(pack_we),
    .rom_off(rom_off), .psram_off(psram_off), .pack_off(pack_off),
    .sram_off(sram_off), .ctrl_idx(ctrl_idx)
  );

  typedef struct {
    logic [6:0]  sel;
    logic [31:0] off;
    logic        we;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic logic [12:2] mk(bit mode, bit psl, bit psh, bit [1:0] pl,
                                     bit rl, bit rh, bit el, bit eh, bit eloc, bit we);
    return {we, eloc, eh, el, rh, rl, pl, psh, psl, mode};
  endfunction

  task automatic drive(logic [23:0] a, bit w, logic [12:2] c,
                       logic [6:0] s, logic [31:0] o, bit we, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    addr = a; wr = w; map_cfg = c;
    e.sel = s; e.off = o; e.we = we; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic logic [31:0] pick(logic [6:0] s);
    case (s)
      S_ROM:   return 32'(rom_off);
      S_PS:    return 32'(psram_off);
      S_PK:    return 32'(pack_off);
      S_SR:    return 32'(sram_off);
      S_CT:    return 32'(ctrl_idx);
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      logic [31:0] got;
      e = q.pop_front();
      n_chk++;
      if (sel !== e.sel) begin
        n_fail++;
        $display("FAIL %s sel: actual %b expected %b", e.tag, sel, e.sel);
      end
      got = pick(e.sel);
      n_chk++;
      if (got !== e.off) begin
        n_fail++;
        $display("FAIL %s offset: actual %h expected %h", e.tag, got, e.off);
      end
      n_chk++;
      if (pack_we !== e.we) begin
        n_fail++;
        $display("FAIL %s pack_we: actual %b expected %b", e.tag, pack_we, e.we);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:2] rst_cfg, c;
    rst_cfg = 11'b01011111011;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-state mapping
    drive(24'h008000, 0, rst_cfg, S_ROM, 32'h0, 0, "R3 reset rom");
    drive(24'h005000, 0, rst_cfg, S_CT, 32'h0, 0, "R1 ctrl 00");
    drive(24'h0F5ABC, 0, rst_cfg, S_CT, 32'hF, 0, "R1 ctrl 0F");
    drive(24'h135123, 0, rst_cfg, S_SR, 32'h3123, 0, "R2 sram");
    drive(24'h185000, 0, rst_cfg, S_OP, 32'h0, 0, "R11 open 18:5000");

    // boot ROM
    c = mk(0,0,0,0, 0,1, 0,0,0, 0);
    drive(24'h859234, 0, c, S_ROM, 32'h29234, 0, "R3 rom fast");
    drive(24'h059234, 0, c, S_PK, 32'h29234, 0, "R3 rom slow off");
    c = mk(0,0,0,0, 1,0, 0,0,0, 0);
    drive(24'h3FFFFF, 0, c, S_ROM, 32'hFFFFF, 0, "R3 rom wrap");
    c = mk(0,1,0,2'd0, 1,0, 0,0,0, 0);
    drive(24'h028000, 0, c, S_ROM, 32'h10000, 0, "R3 rom over psram");

    // LoROM PSRAM
    c = mk(0,1,0,2'd0, 0,0, 0,0,0, 0);
    drive(24'h028000, 0, c, S_PS, 32'h10000, 0, "R4 lo loc0");
    drive(24'h731234, 0, c, S_PS, 32'h19234, 0, "R5 fixed 73");
    drive(24'h7B1234, 0, c, S_PS, 32'h19234, 0, "R5 fixed mirror");
    drive(24'h739234, 0, c, S_PK, 32'h99234, 0, "R5 fixed upper");
    drive(24'h7E1234, 0, c, S_OP, 32'h0, 0, "R11 bank 7E");
    drive(24'h216000, 0, c, S_OP, 32'h0, 0, "R7 lo no snippet");
    c = mk(0,1,0,2'd2, 0,0, 0,0,0, 0);
    drive(24'h451234, 0, c, S_PS, 32'h29234, 0, "R4 lo loc2 low");
    drive(24'h459234, 0, c, S_PS, 32'h29234, 0, "R4 lo loc2 mirror");
    drive(24'h2A8001, 0, c, S_PK, 32'h50001, 0, "R10 lo pack 2A");
    c = mk(0,0,1,2'd1, 0,0, 0,0,0, 0);
    drive(24'hA38010, 0, c, S_PS, 32'h18010, 0, "R8 fast loc1");
    drive(24'h238010, 0, c, S_PK, 32'h18010, 0, "R8 slow disabled");
    drive(24'hA30010, 0, c, S_OP, 32'h0, 0, "R11 fast low half");
    drive(24'hF97FFF, 0, c, S_PS, 32'hFFFF, 0, "R5 fixed fast");

    // HiROM PSRAM
    c = mk(1,1,0,2'd1, 0,0, 0,0,0, 0);
    drive(24'h53ABCD, 0, c, S_PS, 32'h3ABCD, 0, "R6 hi full");
    drive(24'h138000, 0, c, S_PS, 32'h38000, 0, "R6 hi upper");
    drive(24'h130000, 0, c, S_OP, 32'h0, 0, "R6 hi lower open");
    drive(24'h580000, 0, c, S_PK, 32'h80000, 0, "R10 hi pack 58");
    c = mk(1,0,1,2'd3, 0,0, 0,0,0, 0);
    drive(24'hF70001, 0, c, S_PS, 32'h70001, 0, "R6 hi fast loc3");
    c = mk(1,1,0,2'd0, 0,0, 0,0,0, 0);
    drive(24'h216000, 0, c, S_PS, 32'h16000, 0, "R7 snippet 21");
    drive(24'h2A7FFF, 0, c, S_PS, 32'h27FFF, 0, "R7 snippet 2A");
    drive(24'hA16000, 0, c, S_OP, 32'h0, 0, "R8 snippet fast off");
    c = mk(1,0,1,2'd2, 0,0, 0,0,0, 0);
    drive(24'hB96100, 0, c, S_PS, 32'h16100, 0, "R7 snippet fast");

    // external-memory hole
    c = mk(0,0,0,0, 0,0, 1,0,0, 0);
    drive(24'h1FFFFF, 0, c, S_EXT, 32'h0, 0, "R9 lo loc0 hole");
    drive(24'h208000, 0, c, S_PK, 32'h0, 0, "R9 lo loc0 edge");
    c = mk(0,0,0,0, 0,0, 0,1,1, 0);
    drive(24'hC00000, 0, c, S_EXT, 32'h0, 0, "R9 lo loc1 C0");
    drive(24'hDFFFFF, 0, c, S_EXT, 32'h0, 0, "R9 lo loc1 DF");
    drive(24'hE00000, 0, c, S_PK, 32'h0, 0, "R9 lo loc1 edge");
    c = mk(1,0,0,0, 0,0, 1,0,1, 0);
    drive(24'h2F8000, 0, c, S_EXT, 32'h0, 0, "R9 hi loc1 2F");
    drive(24'h6F0000, 0, c, S_EXT, 32'h0, 0, "R9 hi loc1 6F");
    drive(24'h2F0000, 0, c, S_OP, 32'h0, 0, "R9 hi lower open");
    drive(24'h4F0000, 0, c, S_PK, 32'hF0000, 0, "R9 hi pack 4F");
    c = mk(0,1,0,2'd0, 0,0, 1,0,0, 0);
    drive(24'h058000, 0, c, S_PS, 32'h28000, 0, "R9 psram over hole");
    c = mk(0,0,0,0, 0,0, 1,0,0, 1);
    drive(24'h108000, 1, c, S_EXT, 32'h0, 0, "R10 no we on hole");

    // data pack and writes
    c = mk(0,0,0,0, 0,0, 0,0,0, 0);
    drive(24'h400000, 1, c, S_PK, 32'h0, 0, "R10 write locked");
    drive(24'h408123, 0, c, S_PK, 32'h123, 0, "R10 lo pack 40");
    drive(24'hC58123, 0, c, S_PK, 32'h28123, 0, "R10 lo pack C5");
    c = mk(0,0,0,0, 0,0, 0,0,0, 1);
    drive(24'h400000, 1, c, S_PK, 32'h0, 1, "R10 write allowed");
    drive(24'h400000, 0, c, S_PK, 32'h0, 0, "R10 read no we");
    c = mk(1,0,0,0, 0,0, 0,0,0, 0);
    drive(24'hFFFFFF, 0, c, S_PK, 32'hFFFFF, 0, "R10 hi pack FF");
    drive(24'h7D1234, 0, c, S_PK, 32'hD1234, 0, "R10 hi pack 7D");
    drive(24'hFE0000, 0, c, S_PK, 32'hE0000, 0, "R10 hi pack FE");
    drive(24'h7F0000, 0, c, S_OP, 32'h0, 0, "R11 bank 7F");

    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule